// File: doc/BRIEF.md
# Core-Local Interrupt Arbiter

This block gathers a vector of interrupt lines next to a processor core and decides which of them, if any, is presented to the core. Every line has a small set of per-source settings held in a word-addressed register file: an enable, a trigger style (level, rising edge or falling edge), a dispatch style (vectored or shared entry), and an 8-bit control byte. A global setting chooses how many upper bits of every control byte act as the interrupt level. The lower bits act as a priority within that level.

The arbiter selects among the sources that are both enabled and pending. It compares level first, then priority, and on a full tie it takes the larger source number. A request is raised only when the winner's level is strictly greater than a programmable threshold. When that happens the block drives out the winner's number, its level byte and its dispatch style. The core acknowledges a taken interrupt through a claim strobe that carries the source number. The claim clears the latched pending state of an edge-triggered source.

Register words (address bits [8:0]): 0x000 holds the level-bit count, 0x001 is the read-only info word, 0x002 is the threshold, and 0x100 + n is the word for source n. Source 0x3 is meant for a software-raised interrupt and source 0x7 for the system timer. Sources numbered 19 and up are external lines.

Top module: `core_irq_arbiter`

## Requirements
- R1: After reset the level-bit count, the threshold and every source word read as zero, and irqReq is low.
- R2: Word 0x001 reads as {8'h00, VERSION[7:0], NUM_SRC[15:0]}; with the defaults this is 0x0012_0020.
- R3: With L level bits (word 0x000 bits [3:0]), a source's level byte is its control byte with the lowest 8-L bits forced to one. Its priority is those lowest 8-L bits of the control byte. irqLevel shows the winner's level byte.
- R4: irqReq is high only when an eligible winner exists and its level byte is strictly greater than the threshold (word 0x002 bits [7:0]). While irqReq is low, irqId, irqLevel and irqVec are zero.
- R5: Among eligible sources the winner has the highest level byte, then the highest priority, and a remaining tie goes to the larger source number.
- R6: In level mode (trigger field 2'b00 or 2'b11) a source is pending exactly while its input is high, in the same cycle. Software writes to its pending bit have no effect.
- R7: In rising mode (2'b01) or falling mode (2'b10) the pending bit is set at the clock edge that follows the selected input transition. It then stays set after the input returns.
- R8: The latched pending bit of an edge-mode source is cleared by a claim naming that source. A source-word write loads bit 0 into it, so software can clear or set it.
- R9: A source whose enable bit is zero never wins, whatever its input or pending state.
- R10: irqVec equals the vectored-dispatch bit of the winning source.
- R11: Source words at or above NUM_SRC, and unassigned global words, read as zero. Writes to them change no other register.
- R12: A level-bit count above 8 written to word 0x000 is stored and read back as 8.

Source word layout: [0] pending, [1] enable, [2] vectored, [4:3] trigger, [15:8] control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 9 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irqIn | input | NUM_SRC | Raw interrupt lines, synchronous to clk |
| claimValid | input | 1 | Core acknowledges an interrupt |
| claimId | input | ID_W | Source number being acknowledged |
| irqReq | output | 1 | Interrupt request to the core |
| irqId | output | ID_W | Winning source number |
| irqLevel | output | 8 | Winning level byte |
| irqVec | output | 1 | Winner uses vectored dispatch |

## Verification
The arbitration is checked with seeded pseudo-random patterns. Each pattern sets control bytes, enables, dispatch bits and input levels across all 32 sources under a random level-bit count and threshold. These patterns separate level-first ordering from priority ordering and from ID tie-breaking (R5), and they catch disabled sources that leak into the result (R9). A sweep over every level-bit count against many control bytes pins down where the level/priority split falls (R3). A grid of control bytes against thresholds, including equal values, separates strict from non-strict gating (R4). Directed edge sequences show when a latch happens and that it holds (R7), and they distinguish claim clearing from software clearing (R8).

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_LVL2  = 2'd3
  } trigMode_t;

  typedef enum logic [2:0] {
    RD_ZERO = 3'd0,
    RD_CFG  = 3'd1,
    RD_INFO = 3'd2,
    RD_THR  = 3'd3,
    RD_SRC  = 3'd4
  } rdSel_t;

  // strobes from decode control to the datapath
  typedef struct packed {
    logic   cfgWr;
    logic   thrWr;
    logic   srcWr;
    logic   claimHit;
    rdSel_t rdSel;
  } busStrobe_t;

  typedef struct packed {
    logic [7:0] ctl;
    trigMode_t  trig;
    logic       vec;
    logic       en;
  } srcAttr_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import lic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 9,
  parameter int ID_W    = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              claimValid,
  input  logic [ID_W-1:0]   claimId,
  output busStrobe_t        strobe,
  output logic [ID_W-1:0]   srcIdx,
  output logic [ID_W-1:0]   claimIdx
);
  localparam int SRC_IDX_W = ADDR_W - 1;

  logic                 inSrcSpace;
  logic [SRC_IDX_W-1:0] rawIdx;
  logic                 srcOk;

  assign inSrcSpace = regAddr[ADDR_W-1];
  assign rawIdx     = regAddr[SRC_IDX_W-1:0];
  // R11: only implemented source numbers decode to a source word
  assign srcOk      = inSrcSpace && (32'(rawIdx) < 32'(NUM_SRC));
  assign srcIdx     = rawIdx[ID_W-1:0];
  assign claimIdx   = claimId;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_ZERO;
    strobe.claimHit = claimValid && (32'(claimId) < 32'(NUM_SRC));
    if (srcOk) begin
      strobe.rdSel = RD_SRC;
      strobe.srcWr = regWe;
    end else if (!inSrcSpace) begin
      case (rawIdx)
        SRC_IDX_W'(0): begin strobe.rdSel = RD_CFG;  strobe.cfgWr = regWe; end
        SRC_IDX_W'(1): begin strobe.rdSel = RD_INFO; end
        SRC_IDX_W'(2): begin strobe.rdSel = RD_THR;  strobe.thrWr = regWe; end
        default:       strobe.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import lic_pkg::*;
#(
  parameter int         NUM_SRC = 32,
  parameter int         ID_W    = 5,
  parameter logic [7:0] VERSION = 8'h12
) (
  input  logic               clk,
  input  logic               rst,
  input  busStrobe_t         strobe,
  input  logic [ID_W-1:0]    srcIdx,
  input  logic [ID_W-1:0]    claimIdx,
  input  logic [31:0]        regWdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [31:0]        regRdata,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId,
  output logic [7:0]         irqLevel,
  output logic               irqVec
);
  localparam int CTL_W = 8;
  localparam int KEY_W = 2 * CTL_W;

  logic [3:0]         lvlBits;
  logic [CTL_W-1:0]   thr;
  srcAttr_t           attr [NUM_SRC];
  logic [NUM_SRC-1:0] pendReg, irqPrev, pendEff, validVec;
  logic [KEY_W-1:0]   keyVec [NUM_SRC];
  logic [CTL_W-1:0]   lowMask;
  logic [3:0]         wrLvl;
  logic               unusedWdata;

  assign unusedWdata = ^regWdata[31:16];
  assign lowMask     = 8'hFF >> lvlBits;
  assign wrLvl       = (regWdata[3:0] > 4'd8) ? 4'd8 : regWdata[3:0];

  // global settings
  always_ff @(posedge clk) begin
    if (rst) begin
      lvlBits <= '0;
      thr     <= '0;
      irqPrev <= '0;
    end else begin
      if (strobe.cfgWr) lvlBits <= wrLvl;
      if (strobe.thrWr) thr <= regWdata[7:0];
      irqPrev <= irqIn;
    end
  end

  assert_lvl_clamp_R12: assert property (@(posedge clk) disable iff (rst)
    lvlBits <= 4'd8);

  // per-source state, detection and sort key
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic isEdge, edgeHit, wrHere, clmHere;
    assign isEdge  = (attr[g].trig == TRIG_RISE) || (attr[g].trig == TRIG_FALL);
    assign edgeHit = ((attr[g].trig == TRIG_RISE) &&  irqIn[g] && !irqPrev[g]) ||
                     ((attr[g].trig == TRIG_FALL) && !irqIn[g] &&  irqPrev[g]);
    assign wrHere  = strobe.srcWr && (srcIdx == ID_W'(g));
    assign clmHere = strobe.claimHit && (claimIdx == ID_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        attr[g]    <= '0;
        pendReg[g] <= 1'b0;
      end else if (wrHere) begin
        attr[g].ctl  <= regWdata[15:8];
        attr[g].trig <= trigMode_t'(regWdata[4:3]);
        attr[g].vec  <= regWdata[2];
        attr[g].en   <= regWdata[1];
        pendReg[g]   <= regWdata[0] && (regWdata[4:3] == 2'd1 || regWdata[4:3] == 2'd2);
      end else if (!isEdge) begin
        pendReg[g] <= 1'b0;
      end else if (clmHere) begin
        pendReg[g] <= edgeHit;
      end else if (edgeHit) begin
        pendReg[g] <= 1'b1;
      end
    end

    assign pendEff[g]  = isEdge ? pendReg[g] : irqIn[g];
    assign validVec[g] = pendEff[g] && attr[g].en;
    assign keyVec[g]   = {attr[g].ctl | lowMask, attr[g].ctl & lowMask};

    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (rst)
      (edgeHit && !wrHere && !clmHere) |=> pendReg[g]);

    assert_claim_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (clmHere && isEdge && !edgeHit && !wrHere) |=> !pendReg[g]);

    assert_arb_order_R5: assert property (@(posedge clk) disable iff (rst)
      (irqReq && validVec[g]) |->
        ((keyVec[g] < keyVec[irqId]) ||
         ((keyVec[g] == keyVec[irqId]) && (ID_W'(g) <= irqId))));
  end

  // arbitration: linear scan, later (larger) IDs win ties
  logic             found;
  logic [KEY_W-1:0] bestKey;
  logic [ID_W-1:0]  bestId;
  logic             fire;

  always_comb begin
    found   = 1'b0;
    bestKey = '0;
    bestId  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (validVec[i] && (!found || keyVec[i] >= bestKey)) begin
        found   = 1'b1;
        bestKey = keyVec[i];
        bestId  = ID_W'(i);
      end
    end
  end

  assign fire     = found && (bestKey[KEY_W-1:CTL_W] > thr);
  assign irqReq   = fire;
  assign irqId    = fire ? bestId : '0;
  assign irqLevel = fire ? bestKey[KEY_W-1:CTL_W] : '0;
  assign irqVec   = fire && attr[bestId].vec;

  assert_thr_gate_R4: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (irqLevel > thr));

  assert_winner_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> validVec[irqId]);

  // readback
  always_comb begin
    case (strobe.rdSel)
      RD_CFG:  regRdata = {28'b0, lvlBits};
      RD_INFO: regRdata = {8'b0, VERSION, 16'(NUM_SRC)};
      RD_THR:  regRdata = {24'b0, thr};
      RD_SRC:  regRdata = {16'b0, attr[srcIdx].ctl, 3'b0, attr[srcIdx].trig,
                           attr[srcIdx].vec, attr[srcIdx].en, pendEff[srcIdx]};
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/core_irq_arbiter.sv
module core_irq_arbiter
  import lic_pkg::*;
#(
  parameter int         NUM_SRC = 32,
  parameter int         ADDR_W  = 9,
  parameter logic [7:0] VERSION = 8'h12,
  localparam int        ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               claimValid,
  input  logic [ID_W-1:0]    claimId,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId,
  output logic [7:0]         irqLevel,
  output logic               irqVec
);
  busStrobe_t      strobe;
  logic [ID_W-1:0] srcIdx;
  logic [ID_W-1:0] claimIdx;

  irq_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) uCtrl (
    .regAddr    (regAddr),
    .regWe      (regWe),
    .claimValid (claimValid),
    .claimId    (claimId),
    .strobe     (strobe),
    .srcIdx     (srcIdx),
    .claimIdx   (claimIdx)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .VERSION(VERSION)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .srcIdx   (srcIdx),
    .claimIdx (claimIdx),
    .regWdata (regWdata),
    .irqIn    (irqIn),
    .regRdata (regRdata),
    .irqReq   (irqReq),
    .irqId    (irqId),
    .irqLevel (irqLevel),
    .irqVec   (irqVec)
  );

endmodule

// File: tb/tb_core_irq_arbiter.sv
`timescale 1ns/1ps
module tb_core_irq_arbiter;
  localparam int N = 32;
  localparam logic [8:0] A_CFG = 9'h000, A_INFO = 9'h001, A_THR = 9'h002, A_SRC = 9'h100;

  logic        clk = 0;
  logic        rst = 1;
  logic [8:0]  regAddr = '0;
  logic        regWe = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [N-1:0] irqIn = '0;
  logic        claimValid = 0;
  logic [4:0]  claimId = '0;
  logic        irqReq;
  logic [4:0]  irqId;
  logic [7:0]  irqLevel;
  logic        irqVec;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_irq_arbiter dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .irqIn(irqIn), .claimValid(claimValid), .claimId(claimId),
    .irqReq(irqReq), .irqId(irqId), .irqLevel(irqLevel), .irqVec(irqVec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
    #1;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [31:0] srcWord(input logic [7:0] ctl, input logic [1:0] trig,
                                          input logic vec, input logic en, input logic pend);
    return {16'h0, ctl, 3'b0, trig, vec, en, pend};
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic clearAll();
    irqIn = '0;
    for (int i = 0; i < N; i++) wr(A_SRC + 9'(i), 32'h0);
    wr(A_THR, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed;
    logic [7:0]  bCtl [N];
    logic        bEn [N];
    logic        bVec [N];
    logic [7:0]  m, lvl, thrV;
    logic [15:0] key, best;
    logic [4:0]  bestId;
    logic        fnd, expReq;
    int          lb;

    repeat (3) @(negedge clk);
    rst = 0;
    #1;

    // R1 reset state
    check("R1 irqReq", 32'(irqReq), 32'd0);
    rd(A_CFG, d);  check("R1 cfg", d, 32'd0);
    rd(A_THR, d);  check("R1 thr", d, 32'd0);
    rd(A_SRC + 9'd5, d); check("R1 src5", d, 32'd0);
    rd(A_SRC + 9'd31, d); check("R1 src31", d, 32'd0);

    // R2 info word
    rd(A_INFO, d); check("R2 info", d, 32'h0012_0020);

    // R3 level split sweep on source 9
    irqIn = 32'(1) << 9;
    for (int l = 0; l <= 8; l++) begin
      wr(A_CFG, 32'(l));
      m = 8'hFF >> l;
      for (int c = 0; c < 256; c += 3) begin
        wr(A_SRC + 9'd9, srcWord(8'(c), 2'd0, 1'b0, 1'b1, 1'b0));
        lvl = 8'(c) | m;
        expReq = (lvl != 8'd0);
        check("R3 req", 32'(irqReq), 32'(expReq));
        check("R3 level", 32'(irqLevel), expReq ? 32'(lvl) : 32'd0);
      end
    end

    // R4 threshold grid, L=8 so level byte equals control byte
    wr(A_CFG, 32'd8);
    for (int c = 0; c < 256; c += 15) begin
      wr(A_SRC + 9'd9, srcWord(8'(c), 2'd0, 1'b0, 1'b1, 1'b0));
      for (int t = 0; t < 256; t += 15) begin
        wr(A_THR, 32'(t));
        check("R4 strict gate", 32'(irqReq), 32'(c > t));
        check("R4 gated id", 32'(irqId), (c > t) ? 32'd9 : 32'd0);
      end
      wr(A_THR, 32'(c));
      check("R4 equal blocks", 32'(irqReq), 32'd0);
    end

    // R5 tie on full key goes to larger ID
    clearAll();
    wr(A_SRC + 9'd4,  srcWord(8'h5A, 2'd0, 1'b0, 1'b1, 1'b0));
    wr(A_SRC + 9'd20, srcWord(8'h5A, 2'd0, 1'b1, 1'b1, 1'b0));
    irqIn = (32'(1) << 4) | (32'(1) << 20);
    #1;
    check("R5 tie larger id", 32'(irqId), 32'd20);
    check("R10 vec of winner", 32'(irqVec), 32'd1);

    // R9 everything asserted but nothing enabled
    clearAll();
    for (int i = 0; i < N; i++) wr(A_SRC + 9'(i), srcWord(8'hFF, 2'd0, 1'b1, 1'b0, 1'b0));
    irqIn = '1;
    #1;
    check("R9 disabled never win", 32'(irqReq), 32'd0);

    // R5 R9 R10 R4 random arbitration patterns
    seed = 32'h1234_5678;
    for (int tr = 0; tr < 40; tr++) begin
      irqIn = '0;
      seed = xs(seed); lb = int'(seed % 9);
      wr(A_CFG, 32'(lb));
      seed = xs(seed); thrV = (tr % 2 == 0) ? 8'h00 : seed[7:0];
      wr(A_THR, 32'(thrV));
      for (int i = 0; i < N; i++) begin
        seed = xs(seed);
        bCtl[i] = (tr % 3 == 0) ? {seed[7:5], 5'b0} : seed[7:0];
        bEn[i]  = seed[8] | seed[9];
        bVec[i] = seed[10];
        wr(A_SRC + 9'(i), srcWord(bCtl[i], 2'd0, bVec[i], bEn[i], 1'b0));
      end
      seed = xs(seed);
      irqIn = seed;
      #1;
      m = 8'hFF >> lb;
      fnd = 0; best = '0; bestId = '0;
      for (int i = 0; i < N; i++) begin
        key = {bCtl[i] | m, bCtl[i] & m};
        if (seed[i] && bEn[i] && (!fnd || key >= best)) begin
          fnd = 1; best = key; bestId = 5'(i);
        end
      end
      expReq = fnd && (best[15:8] > thrV);
      check("R4 R9 random req", 32'(irqReq), 32'(expReq));
      check("R5 random id", 32'(irqId), expReq ? 32'(bestId) : 32'd0);
      check("R3 random level", 32'(irqLevel), expReq ? 32'(best[15:8]) : 32'd0);
      check("R10 random vec", 32'(irqVec), expReq ? 32'(bVec[bestId]) : 32'd0);
    end

    // R6 level mode follows input; software pending write ignored
    clearAll();
    wr(A_CFG, 32'd8);
    wr(A_SRC + 9'd3, srcWord(8'hFF, 2'd0, 1'b0, 1'b1, 1'b0));
    irqIn[3] = 1; #1;
    check("R6 level high req", 32'(irqReq), 32'd1);
    rd(A_SRC + 9'd3, d); check("R6 pend bit", 32'(d[0]), 32'd1);
    irqIn[3] = 0; #1;
    check("R6 level low req", 32'(irqReq), 32'd0);
    wr(A_SRC + 9'd3, srcWord(8'hFF, 2'd0, 1'b0, 1'b1, 1'b1));
    check("R6 sw pend ignored", 32'(irqReq), 32'd0);

    // R7 rising edge latch
    clearAll();
    wr(A_SRC + 9'd7, srcWord(8'h80, 2'd1, 1'b0, 1'b1, 1'b0));
    irqIn[7] = 1; #1;
    check("R7 rise not yet", 32'(irqReq), 32'd0);
    @(negedge clk); #1;
    check("R7 rise latched", 32'(irqReq), 32'd1);
    check("R7 rise id", 32'(irqId), 32'd7);
    irqIn[7] = 0;
    @(negedge clk); #1;
    check("R7 rise held", 32'(irqReq), 32'd1);

    // R8 claim clears
    claimValid = 1; claimId = 5'd7;
    @(negedge clk); claimValid = 0; #1;
    check("R8 claim clears", 32'(irqReq), 32'd0);
    rd(A_SRC + 9'd7, d); check("R8 pend after claim", 32'(d[0]), 32'd0);
    // R8 software set and clear
    wr(A_SRC + 9'd7, srcWord(8'h80, 2'd1, 1'b0, 1'b1, 1'b1));
    check("R8 sw set", 32'(irqReq), 32'd1);
    wr(A_SRC + 9'd7, srcWord(8'h80, 2'd1, 1'b0, 1'b1, 1'b0));
    check("R8 sw clear", 32'(irqReq), 32'd0);

    // R7 falling edge latch
    wr(A_SRC + 9'd7, srcWord(8'h80, 2'd2, 1'b0, 1'b1, 1'b0));
    irqIn[7] = 1;
    @(negedge clk); #1;
    check("R7 rise ignored in fall mode", 32'(irqReq), 32'd0);
    irqIn[7] = 0; #1;
    check("R7 fall not yet", 32'(irqReq), 32'd0);
    @(negedge clk); #1;
    check("R7 fall latched", 32'(irqReq), 32'd1);

    // R11 unimplemented words
    clearAll();
    wr(A_SRC + 9'd40, srcWord(8'hFF, 2'd0, 1'b1, 1'b1, 1'b0));
    rd(A_SRC + 9'd40, d); check("R11 unimpl read", d, 32'd0);
    rd(A_SRC + 9'd8, d);  check("R11 no alias", d, 32'd0);
    irqIn[8] = 1; #1;
    check("R11 no alias req", 32'(irqReq), 32'd0);
    wr(9'h003, 32'hFF);
    rd(9'h003, d); check("R11 gap read", d, 32'd0);
    rd(A_THR, d);  check("R11 thr untouched", d, 32'd0);

    // R12 clamp
    wr(A_CFG, 32'd15);
    rd(A_CFG, d); check("R12 clamp", d, 32'd8);

    finishRun();
  end

endmodule